// File: doc/BRIEF.md
# Block-Transfer DMA Controller with Request/Grant/Acknowledge Bus Handshake

This block is a single-channel direct memory access engine. A host processor programs a memory start address, a word count, a device-side location, a direction and a transfer mode through a small register port, then arms the channel with a start bit. From that point the controller moves the whole block between a device port and memory on its own, and the host takes no part in the individual words.

The system bus is shared with the host. The controller asks for it with a request line and waits for the host's grant. It then takes ownership by raising an acknowledge line and dropping its request. While it holds the bus it drives the memory address and the read or write strobes itself, one word per cycle in which the device is ready. In burst mode it keeps the bus until the block is finished. In cycle-steal mode it returns the bus after every word and goes through the full request, grant and acknowledge sequence again for the next word. When the last word has moved, a done flag and the interrupt line are raised. The interrupt stays up until the host clears the done flag.

Top module: `dmac_top`

## Requirements
- R1: After a synchronous reset, `bus_req`, `bus_ack` and `irq` are low, and the status register (offset 1) reads zero.
- R2: The register offsets are: 0 control (bit0 start, bit1 direction with 1 = memory to device, bit2 mode with 1 = cycle steal), 1 status (bit0 busy, bit1 done), 2 memory address, 3 count, 4 device location. A read returns the current value, and control reads back its direction and mode bits with bit0 as zero.
- R3: `bus_ack` rises only after `bus_grant` was high at the previous clock edge, so the controller drives no bus signal before it has been granted.
- R4: `bus_req` and `bus_ack` are never high in the same cycle, and `bus_req` drops in the cycle in which `bus_ack` rises.
- R5: In burst mode a block of N words makes exactly one request and one acknowledge interval. `bus_ack` stays high until the last word and drops in the cycle after it.
- R6: In cycle-steal mode `bus_ack` drops in the cycle after every word, and a block of N words makes N request and N acknowledge intervals.
- R7: `bus_req` is raised only after the device was ready and `bus_grant` was low at the previous edge, so no new request is made while an earlier grant is still up.
- R8: Each word moves in one cycle. With direction 0, `dev_rd` and `mem_wr` are high and `mem_wdata` carries `dev_rdata`. With direction 1, `mem_rd` and `dev_wr` are high and `dev_wdata` carries `mem_rdata`. `mem_addr` starts at the programmed address and rises by one per word, the count falls by one per word, and `dev_addr` holds the programmed device location.
- R9: When the last word has moved, done is set, busy clears and `irq` rises. Writing 1 to status bit1 clears done and `irq`. A new start also clears done.
- R10: A start with a count of zero sets done and `irq` at once and never raises `bus_req`.
- R11: While busy, writes to the control, memory address, count and device location registers (including a second start) have no effect.
- R12: Whenever `bus_ack` is low, `mem_addr`, `mem_wdata`, `mem_rd`, `mem_wr`, `dev_addr`, `dev_wdata`, `dev_rd` and `dev_wr` are all zero.
- R13: In burst mode, a cycle in which `dev_ready` is low moves no word and produces no strobe, and the bus stays owned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register offset |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data for the offset on `cfg_addr` |
| bus_req | output | 1 | Request for the system bus |
| bus_grant | input | 1 | Grant from the host |
| bus_ack | output | 1 | Grant acknowledge; the controller owns the bus while this is high |
| mem_addr | output | 16 | Memory address, zero when the bus is not owned |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| dev_ready | input | 1 | Device ready for a word |
| dev_addr | output | 8 | Device-side location |
| dev_wdata | output | 16 | Data to the device |
| dev_rdata | input | 16 | Data from the device |
| dev_rd | output | 1 | Device read strobe |
| dev_wr | output | 1 | Device write strobe |
| irq | output | 1 | Completion interrupt |

## Verification
The embedded properties check, on every cycle, the handshake ordering: no acknowledge without an earlier grant, no request together with an acknowledge, no new request while a grant is still high, release after each word in cycle-steal mode and hold in burst mode. They also check the quiet bus outside ownership, the one-step address and count sequencing, and that register writes are ignored while busy. Only the bench scenarios show that the right number of words reaches the right memory locations with the right data in both directions, that request and acknowledge intervals are counted per block as each mode requires, that zero-length blocks finish without a request, and that the interrupt is raised and cleared through the status register.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] OFF_CTRL  = 3'd0;
    localparam logic [REG_AW-1:0] OFF_STAT  = 3'd1;
    localparam logic [REG_AW-1:0] OFF_MADDR = 3'd2;
    localparam logic [REG_AW-1:0] OFF_COUNT = 3'd3;
    localparam logic [REG_AW-1:0] OFF_DADDR = 3'd4;

    localparam int CTRL_START = 0;
    localparam int CTRL_DIR   = 1;
    localparam int CTRL_MODE  = 2;

    localparam int STAT_BUSY  = 0;
    localparam int STAT_DONE  = 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_REQ  = 2'd2,
        ST_OWN  = 2'd3
    } chan_state_e;

    typedef struct packed {
        logic steal;   // 1: give the bus back after every word
        logic to_dev;  // 1: memory to device, 0: device to memory
    } xfer_cfg_t;

    function automatic logic is_last(input logic [31:0] remaining);
        return remaining == 32'd1;
    endfunction

endpackage

// File: rtl/dmac_regs.sv
module dmac_regs
    import dmac_pkg::*;
#(
    parameter int REG_W  = 16,
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int DEV_AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [REG_AW-1:0] cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic              busy,
    input  logic              xfer,
    input  logic              set_done,
    output logic              start,
    output xfer_cfg_t         cfg,
    output logic [ADDR_W-1:0] maddr,
    output logic [DEV_AW-1:0] daddr,
    output logic              count_zero,
    output logic              count_last,
    output logic              done
);

    logic [CNT_W-1:0] count;
    logic             wr_open;
    logic             done_clr;

    assign wr_open    = cfg_wr && !busy;
    assign start      = wr_open && (cfg_addr == OFF_CTRL) && cfg_wdata[CTRL_START];
    assign done_clr   = cfg_wr && (cfg_addr == OFF_STAT) && cfg_wdata[STAT_DONE];
    assign count_zero = (count == '0);
    assign count_last = is_last(32'(count));

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg   <= '0;
            maddr <= '0;
            daddr <= '0;
            count <= '0;
        end else if (xfer) begin
            maddr <= maddr + ADDR_W'(1);
            count <= count - CNT_W'(1);
        end else if (wr_open) begin
            case (cfg_addr)
                OFF_CTRL: begin
                    cfg.to_dev <= cfg_wdata[CTRL_DIR];
                    cfg.steal  <= cfg_wdata[CTRL_MODE];
                end
                OFF_MADDR: maddr <= cfg_wdata[ADDR_W-1:0];
                OFF_COUNT: count <= cfg_wdata[CNT_W-1:0];
                OFF_DADDR: daddr <= cfg_wdata[DEV_AW-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done <= 1'b0;
        end else if (set_done) begin
            done <= 1'b1;
        end else if (start || done_clr) begin
            done <= 1'b0;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            OFF_CTRL: begin
                cfg_rdata[CTRL_DIR]  = cfg.to_dev;
                cfg_rdata[CTRL_MODE] = cfg.steal;
            end
            OFF_STAT: begin
                cfg_rdata[STAT_BUSY] = busy;
                cfg_rdata[STAT_DONE] = done;
            end
            OFF_MADDR: cfg_rdata = REG_W'(maddr);
            OFF_COUNT: cfg_rdata = REG_W'(count);
            OFF_DADDR: cfg_rdata = REG_W'(daddr);
            default:   cfg_rdata = '0;
        endcase
    end

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        xfer |=> (maddr == $past(maddr) + ADDR_W'(1)) && (count == $past(count) - CNT_W'(1))); // R8

    AST_BUSY_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && cfg_wr && (cfg_addr == OFF_DADDR || cfg_addr == OFF_CTRL)) |=> (daddr == $past(daddr)) && (cfg == $past(cfg))); // R11

    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (done_clr && !set_done) |=> !done); // R9

endmodule

// File: rtl/dmac_arb.sv
module dmac_arb
    import dmac_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      count_zero,
    input  logic      count_last,
    input  xfer_cfg_t cfg,
    input  logic      dev_ready,
    input  logic      bus_grant,
    output logic      bus_req,
    output logic      bus_ack,
    output logic      xfer,
    output logic      set_done,
    output logic      busy
);

    chan_state_e state;
    chan_state_e state_nx;

    assign bus_req  = (state == ST_REQ);
    assign bus_ack  = (state == ST_OWN);
    assign busy     = (state != ST_IDLE);
    assign xfer     = bus_ack && dev_ready;
    assign set_done = ((state == ST_IDLE) && start && count_zero) || (xfer && count_last);

    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE: if (start && !count_zero) state_nx = ST_ARM;
            ST_ARM:  if (dev_ready && !bus_grant) state_nx = ST_REQ;
            ST_REQ:  if (bus_grant) state_nx = ST_OWN;
            ST_OWN: begin
                if (xfer) begin
                    if (count_last)     state_nx = ST_IDLE;
                    else if (cfg.steal) state_nx = ST_ARM;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    AST_NO_REQ_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
        !(bus_req && bus_ack)); // R4

    AST_ACK_AFTER_GRANT: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_ack) |-> $past(bus_grant)); // R3

    AST_REREQ_AFTER_DROP: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_req) |-> (!$past(bus_grant) && $past(dev_ready))); // R7

    AST_STEAL_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (xfer && cfg.steal) |=> !bus_ack); // R6

    AST_BURST_HOLD: assert property (@(posedge clk) disable iff (rst)
        (bus_ack && !cfg.steal && !(xfer && count_last)) |=> bus_ack); // R5

    AST_ZERO_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && count_zero) |=> (!busy && !bus_req)); // R10

endmodule

// File: rtl/dmac_busmux.sv
module dmac_busmux
    import dmac_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int DEV_AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_ack,
    input  logic              xfer,
    input  xfer_cfg_t         cfg,
    input  logic [ADDR_W-1:0] maddr,
    input  logic [DEV_AW-1:0] daddr,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] dev_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DEV_AW-1:0] dev_addr,
    output logic [DATA_W-1:0] dev_wdata,
    output logic              dev_rd,
    output logic              dev_wr
);

    localparam int N_DIR = 2;

    logic [N_DIR-1:0] dir_hit;

    // One strobe pair per direction; index 1 is memory to device.
    for (genvar d = 0; d < N_DIR; d++) begin : g_dir
        assign dir_hit[d] = xfer && (cfg.to_dev == d[0]);
    end

    assign mem_addr  = bus_ack ? maddr : '0;
    assign dev_addr  = bus_ack ? daddr : '0;
    assign mem_wr    = dir_hit[0];
    assign dev_rd    = dir_hit[0];
    assign mem_rd    = dir_hit[1];
    assign dev_wr    = dir_hit[1];
    assign mem_wdata = dir_hit[0] ? dev_rdata : '0;
    assign dev_wdata = dir_hit[1] ? mem_rdata : '0;

    AST_QUIET_BUS: assert property (@(posedge clk) disable iff (rst)
        !bus_ack |-> (mem_addr == '0 && dev_addr == '0 && !mem_rd && !mem_wr && !dev_rd && !dev_wr
                      && mem_wdata == '0 && dev_wdata == '0)); // R12

    AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (rst)
        $countones({mem_rd, mem_wr}) <= 1); // R8

endmodule

// File: rtl/dmac_top.sv
module dmac_top
    import dmac_pkg::*;
#(
    parameter int REG_W  = 16,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16,
    parameter int DEV_AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [2:0]        cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    output logic              bus_req,
    input  logic              bus_grant,
    output logic              bus_ack,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_rd,
    output logic              mem_wr,
    input  logic              dev_ready,
    output logic [DEV_AW-1:0] dev_addr,
    output logic [DATA_W-1:0] dev_wdata,
    input  logic [DATA_W-1:0] dev_rdata,
    output logic              dev_rd,
    output logic              dev_wr,
    output logic              irq
);

    xfer_cfg_t         cfg;
    logic [ADDR_W-1:0] maddr;
    logic [DEV_AW-1:0] daddr;
    logic              start;
    logic              busy;
    logic              xfer;
    logic              set_done;
    logic              count_zero;
    logic              count_last;
    logic              done;

    dmac_regs #(
        .REG_W (REG_W),
        .ADDR_W(ADDR_W),
        .CNT_W (CNT_W),
        .DEV_AW(DEV_AW)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .busy      (busy),
        .xfer      (xfer),
        .set_done  (set_done),
        .start     (start),
        .cfg       (cfg),
        .maddr     (maddr),
        .daddr     (daddr),
        .count_zero(count_zero),
        .count_last(count_last),
        .done      (done)
    );

    dmac_arb u_arb (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .count_zero(count_zero),
        .count_last(count_last),
        .cfg       (cfg),
        .dev_ready (dev_ready),
        .bus_grant (bus_grant),
        .bus_req   (bus_req),
        .bus_ack   (bus_ack),
        .xfer      (xfer),
        .set_done  (set_done),
        .busy      (busy)
    );

    dmac_busmux #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .DEV_AW(DEV_AW)
    ) u_busmux (
        .clk      (clk),
        .rst      (rst),
        .bus_ack  (bus_ack),
        .xfer     (xfer),
        .cfg      (cfg),
        .maddr    (maddr),
        .daddr    (daddr),
        .mem_rdata(mem_rdata),
        .dev_rdata(dev_rdata),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .mem_rd   (mem_rd),
        .mem_wr   (mem_wr),
        .dev_addr (dev_addr),
        .dev_wdata(dev_wdata),
        .dev_rd   (dev_rd),
        .dev_wr   (dev_wr)
    );

    assign irq = done;

    AST_IRQ_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> !bus_ack && !bus_req); // R9

endmodule

// File: tb/dmac_top_tb.sv
module dmac_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_addr = 3'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic [15:0] cfg_rdata;
    logic        bus_req, bus_ack;
    logic        bus_grant;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_rd, mem_wr;
    logic        dev_ready;
    logic [7:0]  dev_addr;
    logic [15:0] dev_wdata, dev_rdata;
    logic        dev_rd, dev_wr;
    logic        irq;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    // reference state
    logic [15:0] mem [0:255];
    int          dev_seen = 0;
    int          mon_idx = 0;
    int          exp_q[$];
    logic        exp_to_dev = 1'b0;
    logic [7:0]  exp_daddr = 8'd0;
    logic        running = 1'b0;
    logic        toggle_rdy = 1'b0;
    int          req_rises = 0;
    int          ack_rises = 0;
    logic        prev_req = 1'b0;
    logic        prev_ack = 1'b0;

    always #10 clk = ~clk;

    dmac_top u_dut (
        .clk(clk), .rst(rst),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .bus_req(bus_req), .bus_grant(bus_grant), .bus_ack(bus_ack),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr),
        .dev_ready(dev_ready), .dev_addr(dev_addr), .dev_wdata(dev_wdata),
        .dev_rdata(dev_rdata), .dev_rd(dev_rd), .dev_wr(dev_wr),
        .irq(irq)
    );

    // host: grants one edge after a request, holds while the bus is owned
    always_ff @(posedge clk) begin
        if (rst) bus_grant <= 1'b0;
        else     bus_grant <= bus_req | (bus_grant & bus_ack);
    end

    // device readiness: steady or alternating
    always_ff @(posedge clk) begin
        if (rst)             dev_ready <= 1'b1;
        else if (toggle_rdy) dev_ready <= ~dev_ready;
        else                 dev_ready <= 1'b1;
    end

    assign mem_rdata = mem[mem_addr[7:0]];
    assign dev_rdata = 16'hD000 + 16'(dev_seen);

    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
        if (dev_rd) dev_seen <= dev_seen + 1;
    end

    task automatic check(input string req, input logic ok, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-cycle comparison against the transfer model
    always @(negedge clk) begin
        if (!rst && running) begin
            if (!bus_ack)
                check("R12 quiet bus", {mem_addr, mem_wdata, dev_wdata, dev_addr, mem_rd, mem_wr, dev_rd, dev_wr} == '0,
                      {mem_addr, dev_addr}, 0);
            check("R4 req/ack exclusive", !(bus_req && bus_ack), {bus_req, bus_ack}, 0);
            if (bus_ack && !dev_ready)
                check("R13 stall no strobe", !(mem_rd || mem_wr || dev_rd || dev_wr),
                      {mem_rd, mem_wr, dev_rd, dev_wr}, 0);
            if (mem_rd || mem_wr) begin
                if (exp_q.size() == 0) begin
                    check("R8 unexpected word", 1'b0, mem_addr, 0);
                end else begin
                    int ea;
                    ea = exp_q.pop_front();
                    check("R8 mem_addr", mem_addr == 16'(ea), mem_addr, ea);
                    check("R8 dev_addr", dev_addr == exp_daddr, dev_addr, exp_daddr);
                    if (exp_to_dev) begin
                        check("R8 m2d strobes", mem_rd && dev_wr && !mem_wr && !dev_rd,
                              {mem_rd, mem_wr, dev_rd, dev_wr}, 4'b1001);
                        check("R8 m2d data", dev_wdata == mem[ea[7:0]], dev_wdata, mem[ea[7:0]]);
                    end else begin
                        check("R8 d2m strobes", mem_wr && dev_rd && !mem_rd && !dev_wr,
                              {mem_rd, mem_wr, dev_rd, dev_wr}, 4'b0110);
                        check("R8 d2m data", mem_wdata == 16'hD000 + 16'(mon_idx), mem_wdata,
                              16'hD000 + 16'(mon_idx));
                        mon_idx++;
                    end
                end
            end
            if (bus_req && !prev_req) req_rises++;
            if (bus_ack && !prev_ack) ack_rises++;
            prev_req = bus_req;
            prev_ack = bus_ack;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(posedge clk); #2;
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); #2;
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(posedge clk); #2;
        cfg_addr = a;
        @(negedge clk);
        d = cfg_rdata;
    endtask

    task automatic wait_irq(input int limit);
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (irq) break;
        end
    endtask

    // run one block and check its outcome
    task automatic run_block(input string tag, input logic steal, input logic to_dev,
                             input int start_a, input int len, input logic [7:0] da,
                             input logic tog, input logic busy_pokes);
        logic [15:0] v;
        int          base;
        base       = dev_seen;
        exp_to_dev = to_dev;
        exp_daddr  = da;
        for (int i = 0; i < len; i++) exp_q.push_back(start_a + i);
        req_rises  = 0;
        ack_rises  = 0;
        wr(3'd2, 16'(start_a));
        wr(3'd3, 16'(len));
        wr(3'd4, {8'h00, da});
        toggle_rdy = tog;
        running    = 1'b1;
        wr(3'd0, {13'd0, steal, to_dev, 1'b1});
        if (busy_pokes) begin
            wr(3'd2, 16'h0077);
            wr(3'd3, 16'd9);
            wr(3'd4, 16'h00EE);
            wr(3'd0, 16'h0001);
            rd(3'd1, v);
            check("R11 busy while poked", v[0] == 1'b1, v, 1);
        end
        wait_irq(2000);
        @(negedge clk);
        running    = 1'b0;
        toggle_rdy = 1'b0;
        check({tag, " R9 irq"}, irq == 1'b1, irq, 1);
        rd(3'd1, v);
        check({tag, " R9 status done"}, v == 16'h0002, v, 2);
        rd(3'd2, v);
        check({tag, " R8/R11 final maddr"}, v == 16'(start_a + len), v, start_a + len);
        rd(3'd3, v);
        check({tag, " R8/R11 final count"}, v == 16'd0, v, 0);
        rd(3'd4, v);
        check({tag, " R11 device location"}, v == {8'h00, da}, v, da);
        check({tag, " R8 all words seen"}, exp_q.size() == 0, exp_q.size(), 0);
        if (steal) begin
            check({tag, " R6 request count"}, req_rises == len, req_rises, len);
            check({tag, " R6 ack count"}, ack_rises == len, ack_rises, len);
        end else begin
            check({tag, " R5 request count"}, req_rises == 1, req_rises, 1);
            check({tag, " R5 ack count"}, ack_rises == 1, ack_rises, 1);
        end
        if (!to_dev)
            for (int i = 0; i < len; i++)
                check({tag, " R8 memory image"}, mem[8'(start_a + i)] == 16'hD000 + 16'(base + i),
                      mem[8'(start_a + i)], 16'hD000 + 16'(base + i));
        wr(3'd1, 16'h0002);
        @(negedge clk);
        check({tag, " R9 irq cleared"}, irq == 1'b0, irq, 0);
        exp_q.delete();
    endtask

    initial begin
        logic [15:0] v;
        for (int i = 0; i < 256; i++) mem[i] = 16'h1000 + 16'(i * 7);
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        check("R1 reset outputs", !bus_req && !bus_ack && !irq, {bus_req, bus_ack, irq}, 0);
        rd(3'd1, v);
        check("R1 reset status", v == 16'd0, v, 0);

        // register readback without start
        wr(3'd2, 16'h0040);
        wr(3'd4, 16'h0035);
        wr(3'd0, 16'h0006);
        rd(3'd2, v);
        check("R2 maddr readback", v == 16'h0040, v, 16'h0040);
        rd(3'd4, v);
        check("R2 dev location readback", v == 16'h0035, v, 16'h0035);
        rd(3'd0, v);
        check("R2 control readback", v == 16'h0006, v, 16'h0006);
        rd(3'd1, v);
        check("R2 idle status", v == 16'h0000, v, 0);

        run_block("burst d2m",       1'b0, 1'b0, 16'h10, 4, 8'h21, 1'b0, 1'b0);
        run_block("steal m2d",       1'b1, 1'b1, 16'h40, 3, 8'h35, 1'b0, 1'b0);
        run_block("burst m2d stall", 1'b0, 1'b1, 16'h80, 5, 8'h12, 1'b1, 1'b1);
        run_block("steal d2m stall", 1'b1, 1'b0, 16'hA0, 2, 8'h44, 1'b1, 1'b0);
        run_block("steal single",    1'b1, 1'b0, 16'hC0, 1, 8'h01, 1'b0, 1'b0);

        // zero-length block: immediate completion, no request
        req_rises = 0;
        running   = 1'b1;
        wr(3'd3, 16'd0);
        wr(3'd0, 16'h0001);
        @(negedge clk);
        check("R10 zero length irq", irq == 1'b1, irq, 1);
        repeat (5) @(negedge clk);
        running = 1'b0;
        check("R10 zero length no request", req_rises == 0, req_rises, 0);
        rd(3'd1, v);
        check("R10 zero length status", v == 16'h0002, v, 2);
        wr(3'd0, 16'h0000);
        rd(3'd1, v);
        check("R9 done kept without clear", v == 16'h0002, v, 2);
        wr(3'd1, 16'h0002);
        @(negedge clk);
        check("R9 irq clear on write", irq == 1'b0, irq, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule